// File: doc/BRIEF.md
# Linear Frequency Sweep Generator

This block produces the tuning word that drives a phase accumulator. It moves that word in a straight line between a lower bound and an upper bound. Each direction has its own control word. The top byte of the control word gives a dwell count, and the low 32 bits give the increment. The tuning word advances by one increment after it has held its value for the dwell count, measured in cycles of `clk`.

`clk` is the step clock, which normally runs at one quarter of the system clock. A dwell of 1 therefore holds each frequency for one step-clock period. With a 400 MHz system clock that period is 10 ns.

A direction input chooses the active control word. When the block is rising it stops exactly on the upper bound, and when it is falling it stops exactly on the lower bound. It never steps past either bound, even when the arithmetic would wrap around 32 bits. When the sweep is disabled, the output rests on the lower bound.

Top module: `chirp_sweep_gen`

## Requirements
- R1: While `sweep_en` is low, `tune_word` takes the value of `lo_word` on the next clock edge, and the dwell count is cleared.
- R2: Bits [39:32] of a control word are the dwell count and bits [31:0] are the increment. `rise_ctl` is used when `sweep_dn` is 0 (rising), and `fall_ctl` is used when `sweep_dn` is 1 (falling).
- R3: While enabled with the direction unchanged and a dwell count N of at least 1, `tune_word` changes once every N clock edges, by exactly one increment. It holds its value between those edges, and a rising sweep never lowers it.
- R4: A dwell count of 0 behaves exactly like a dwell count of 1.
- R5: While rising, `tune_word` never exceeds `hi_word`. A step that would pass `hi_word`, including one that overflows 32 bits, lands exactly on `hi_word`, and the output stays there.
- R6: While falling, `tune_word` never drops below `lo_word`. A step that would pass `lo_word`, including one that borrows below zero, lands exactly on `lo_word`, and the output stays there.
- R7: On the first clock edge after `sweep_dn` changes while enabled, no step is taken and the dwell count restarts from zero.
- R8: While `rst_n` is low, `tune_word` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sweep_en | input | 1 | Runs the sweep when high; parks the output on the lower bound when low |
| sweep_dn | input | 1 | 0 = rising toward `hi_word`, 1 = falling toward `lo_word` |
| lo_word | input | 32 | Lower bound and start tuning word |
| hi_word | input | 32 | Upper bound tuning word |
| rise_ctl | input | 40 | Rising control word: dwell count [39:32], increment [31:0] |
| fall_ctl | input | 40 | Falling control word: dwell count [39:32], increment [31:0] |
| tune_word | output | 32 | Current tuning word to the phase accumulator |

## Verification
The bound assertions assume that `hi_word` is not below `lo_word`. They also assume the output already lies inside the bound being tested, so they only apply when that holds in the current cycle. The direction-change property assumes that `sweep_dn` was valid in the cycle before the change and that reset was not active in that cycle. The stimulus always programs the upper bound at or above the lower bound. It changes the bounds only while the sweep is disabled, and it drives every input from time zero, so each assertion sees only legal input.

// File: rtl/chirp_pkg.sv
package chirp_pkg;
    localparam int unsigned RATE_W_DFLT = 8;
    localparam int unsigned FREQ_W_DFLT = 32;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } sweep_dir_e;
endpackage

// File: rtl/chirp_ctl_pick.sv
module chirp_ctl_pick
    import chirp_pkg::*;
#(
    parameter int unsigned RATE_W = RATE_W_DFLT,
    parameter int unsigned FREQ_W = FREQ_W_DFLT,
    localparam int unsigned CTL_W = RATE_W + FREQ_W
) (
    input  logic              dir_dn,
    input  logic [CTL_W-1:0]  rise_ctl,
    input  logic [CTL_W-1:0]  fall_ctl,
    output logic [RATE_W-1:0] dwell,
    output logic [FREQ_W-1:0] delta
);
    logic [CTL_W-1:0]  active;
    logic [RATE_W-1:0] raw_rate;

    always_comb begin
        active   = (sweep_dir_e'(dir_dn) == DIR_DOWN) ? fall_ctl : rise_ctl;
        raw_rate = active[CTL_W-1:FREQ_W];
        delta    = active[FREQ_W-1:0];
        // a zero dwell count is promoted to one
        dwell    = (raw_rate == '0) ? RATE_W'(1) : raw_rate;
    end
endmodule

// File: rtl/chirp_clamp_step.sv
module chirp_clamp_step
    import chirp_pkg::*;
#(
    parameter int unsigned FREQ_W = FREQ_W_DFLT,
    parameter bit          GO_UP  = 1'b1
) (
    input  logic [FREQ_W-1:0] cur,
    input  logic [FREQ_W-1:0] delta,
    input  logic [FREQ_W-1:0] limit,
    output logic [FREQ_W-1:0] nxt
);
    // one extra bit catches the carry or the borrow
    logic [FREQ_W:0] wide;

    generate
        if (GO_UP) begin : g_up
            always_comb begin
                wide = {1'b0, cur} + {1'b0, delta};
                nxt  = (wide > {1'b0, limit}) ? limit : wide[FREQ_W-1:0];
            end
        end else begin : g_dn
            always_comb begin
                wide = {1'b0, cur} - {1'b0, delta};
                if (wide[FREQ_W] || (wide[FREQ_W-1:0] < limit))
                    nxt = limit;
                else
                    nxt = wide[FREQ_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/chirp_dwell.sv
module chirp_dwell
    import chirp_pkg::*;
#(
    parameter int unsigned RATE_W = RATE_W_DFLT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [RATE_W-1:0] dwell,
    output logic              step
);
    typedef struct packed {
        logic [RATE_W-1:0] cnt;
    } dwell_st_t;

    dwell_st_t       st_d, st_q;
    logic [RATE_W:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        step    = 1'b0;
        cnt_inc = {1'b0, st_q.cnt} + {{RATE_W{1'b0}}, 1'b1};
        if (!run || restart) begin
            st_d.cnt = '0;
        end else if (cnt_inc >= {1'b0, dwell}) begin
            step     = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = cnt_inc[RATE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/chirp_sweep_gen.sv
module chirp_sweep_gen
    import chirp_pkg::*;
#(
    parameter int unsigned RATE_W = RATE_W_DFLT,
    parameter int unsigned FREQ_W = FREQ_W_DFLT,
    localparam int unsigned CTL_W = RATE_W + FREQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sweep_en,
    input  logic              sweep_dn,
    input  logic [FREQ_W-1:0] lo_word,
    input  logic [FREQ_W-1:0] hi_word,
    input  logic [CTL_W-1:0]  rise_ctl,
    input  logic [CTL_W-1:0]  fall_ctl,
    output logic [FREQ_W-1:0] tune_word
);
    typedef struct packed {
        logic [FREQ_W-1:0] tune;
        logic              dir;
    } gen_st_t;

    gen_st_t           st_d, st_q;
    logic [RATE_W-1:0] dwell;
    logic [FREQ_W-1:0] delta;
    logic              step;
    logic              dir_flip;
    logic [FREQ_W-1:0] cand [2];

    assign dir_flip = (sweep_dn != st_q.dir);

    chirp_ctl_pick #(.RATE_W(RATE_W), .FREQ_W(FREQ_W)) pick_i (
        .dir_dn   (sweep_dn),
        .rise_ctl (rise_ctl),
        .fall_ctl (fall_ctl),
        .dwell    (dwell),
        .delta    (delta)
    );

    chirp_dwell #(.RATE_W(RATE_W)) dwell_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (sweep_en),
        .restart (dir_flip),
        .dwell   (dwell),
        .step    (step)
    );

    // index 0 climbs toward hi_word, index 1 descends toward lo_word
    for (genvar g = 0; g < 2; g++) begin : g_clamp
        chirp_clamp_step #(.FREQ_W(FREQ_W), .GO_UP(g == 0)) clamp_i (
            .cur   (st_q.tune),
            .delta (delta),
            .limit ((g == 0) ? hi_word : lo_word),
            .nxt   (cand[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.dir = sweep_dn;
        if (!sweep_en)
            st_d.tune = lo_word;
        else if (step)
            st_d.tune = (sweep_dir_e'(sweep_dn) == DIR_DOWN) ? cand[1] : cand[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tune_word = st_q.tune;
endmodule

// File: rtl/chirp_sweep_chk.sv
module chirp_sweep_chk #(
    parameter int unsigned FREQ_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sweep_en,
    input logic              sweep_dn,
    input logic [FREQ_W-1:0] lo_word,
    input logic [FREQ_W-1:0] hi_word,
    input logic [FREQ_W-1:0] tune_word
);
    // R1
    park_on_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sweep_en |=> tune_word == $past(lo_word));

    // R5
    rise_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && !sweep_dn && tune_word <= hi_word) |=> tune_word <= $past(hi_word));

    // R6
    fall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && sweep_dn && tune_word >= lo_word) |=> tune_word >= $past(lo_word));

    // R3
    rise_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && !sweep_dn && tune_word <= hi_word) |=> tune_word >= $past(tune_word));

    // R7
    flip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && $past(rst_n) && $past(sweep_en) && sweep_dn != $past(sweep_dn))
            |=> tune_word == $past(tune_word));
endmodule

bind chirp_sweep_gen chirp_sweep_chk #(.FREQ_W(FREQ_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sweep_en  (sweep_en),
    .sweep_dn  (sweep_dn),
    .lo_word   (lo_word),
    .hi_word   (hi_word),
    .tune_word (tune_word)
);

// File: tb/chirp_sweep_gen_tb_top.sv
module chirp_sweep_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sweep_en = 1'b0;
    logic        sweep_dn = 1'b0;
    logic [31:0] lo_word = '0;
    logic [31:0] hi_word = '0;
    logic [39:0] rise_ctl = '0;
    logic [39:0] fall_ctl = '0;
    logic [31:0] tune_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    chirp_sweep_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sweep_en  (sweep_en),
        .sweep_dn  (sweep_dn),
        .lo_word   (lo_word),
        .hi_word   (hi_word),
        .rise_ctl  (rise_ctl),
        .fall_ctl  (fall_ctl),
        .tune_word (tune_word)
    );

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
        logic [39:0] rise;
        logic [39:0] fall;
        logic        dn;
        logic [7:0]  edges;
        logic [31:0] expv;
    } vec_t;

    // each vector parks on lo, then runs enabled for 'edges' clock edges
    localparam vec_t VECS [8] = '{
        '{32'd1000, 32'd2000, {8'd1, 32'd10},  40'd0, 1'b0, 8'd5, 32'd1050},              // R3 R2
        '{32'd1000, 32'd2000, {8'd3, 32'd100}, 40'd0, 1'b0, 8'd7, 32'd1200},              // R3 dwell 3
        '{32'd1000, 32'd2000, {8'd3, 32'd100}, 40'd0, 1'b0, 8'd2, 32'd1000},              // R3 hold
        '{32'd1000, 32'd2000, {8'd0, 32'd7},   40'd0, 1'b0, 8'd4, 32'd1028},              // R4
        '{32'd1000, 32'd2000, {8'd1, 32'd300}, 40'd0, 1'b0, 8'd4, 32'd2000},              // R5
        '{32'hFFFF_FF00, 32'hFFFF_FFFF, {8'd1, 32'h80}, 40'd0, 1'b0, 8'd3, 32'hFFFF_FFFF}, // R5 wrap
        '{32'd1000, 32'd2000, {8'd1, 32'd10},  {8'd1, 32'd5}, 1'b1, 8'd3, 32'd1000},      // R6
        '{32'd5, 32'd9, 40'd0, {8'd1, 32'hFFFF_FFF0}, 1'b1, 8'd2, 32'd5}                  // R6 borrow
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        lo_word = 32'd555;
        edges(3);
        chk("R8 reset value", tune_word, 32'd0);
        rst_n = 1'b1;
        edges(1);
        chk("R1 parked on lo", tune_word, 32'd555);
        lo_word = 32'd777;
        edges(1);
        chk("R1 follows lo", tune_word, 32'd777);

        for (int i = 0; i < 8; i++) begin
            sweep_en = 1'b0;
            lo_word  = VECS[i].lo;
            hi_word  = VECS[i].hi;
            rise_ctl = VECS[i].rise;
            fall_ctl = VECS[i].fall;
            sweep_dn = VECS[i].dn;
            edges(1);
            sweep_en = 1'b1;
            edges(int'(VECS[i].edges));
            chk($sformatf("vector %0d (R2 R3 R4 R5 R6)", i), tune_word, VECS[i].expv);
        end

        // climb to the top, then reverse with a one-cycle falling dwell
        sweep_en = 1'b0;
        sweep_dn = 1'b0;
        lo_word  = 32'd0;
        hi_word  = 32'd100;
        rise_ctl = {8'd1, 32'd30};
        fall_ctl = {8'd1, 32'd40};
        edges(1);
        sweep_en = 1'b1;
        edges(4);
        chk("R5 clamp at hi", tune_word, 32'd100);
        edges(2);
        chk("R5 hold at hi", tune_word, 32'd100);
        sweep_dn = 1'b1;
        edges(1);
        chk("R7 no step on reversal", tune_word, 32'd100);
        edges(1);
        chk("R2 falling increment", tune_word, 32'd60);
        edges(1);
        chk("R3 falling step", tune_word, 32'd20);
        edges(1);
        chk("R6 clamp at lo", tune_word, 32'd0);
        edges(2);
        chk("R6 hold at lo", tune_word, 32'd0);

        // disabling mid-sweep returns to lo
        sweep_dn = 1'b0;
        edges(3);
        sweep_en = 1'b0;
        lo_word  = 32'd4;
        edges(1);
        chk("R1 disable mid-sweep", tune_word, 32'd4);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule